// File: doc/BRIEF.md
# Closed-Loop Output Drive Strength Controller

This block trims the drive strength of a bank of output buffers with a feedback loop. It launches a test transition on a reference output (`probe_out`). External logic samples the looped-back return at a chosen fraction of the master clock period and hands that sample back. From the sample the block decides whether the edge came in early or late, and it moves one of two 4-bit strength codes by a single step. One code sets the pull-up strength and so governs rising edges. The other sets the pull-down strength and so governs falling edges. The two codes have opposite polarity. Rising and falling measurements take turns, so each code converges on its own. Once a code has converged, it dithers by one LSB around the deadline.

The boot-time configuration chooses one of three behaviours. The codes can stay fixed at their initial values. They can adapt only while cold reset is held and then freeze. Or they can adapt all the time. The deadline-select field is passed on to the external sample-phase logic. A reserved deadline value forces fixed behaviour and raises `config_error`.

The sample return is a valid/ready stream into the block. `sample_ready` is high only while one launched probe edge awaits its sample. A sample is taken only in a cycle where `sample_valid` and `sample_ready` are both high. The source may hold `sample_valid` high for as long as it likes: samples offered while `sample_ready` is low are ignored. After each accepted sample the block launches the next probe edge and only then raises `sample_ready` again.

Top module: `slew_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pu_code` loads from `init_pu`, `pd_code` loads from `init_pd`, `probe_out` goes to 0 and `sample_ready` is low.
- R2: Each probe launch inverts `probe_out`, so the first launch after reset is rising (1). `sample_ready` then rises in the following cycle and falls in the cycle after an accepted sample. Exactly one sample is accepted per launch.
- R3: A sample accepted while `probe_out`=1 (a rising measurement) adjusts only `pu_code`. A sample of 1 means early, and `pu_code` goes down by one (slower). A sample of 0 means late, and `pu_code` goes up by one (faster, where 15 is fastest).
- R4: A sample accepted while `probe_out`=0 (a falling measurement) adjusts only `pd_code`. A sample of 0 means early, and `pd_code` goes up by one (slower). A sample of 1 means late, and `pd_code` goes down by one (faster, where 0 is fastest).
- R5: Each code saturates at 0 and at 15. A further step in the same direction leaves it unchanged.
- R6: With `mode_sel`=00 the codes never change after reset.
- R7: With `mode_sel`=01 the codes adapt only on samples accepted while `cold_reset`=1. When `cold_reset`=0 they hold.
- R8: With `mode_sel`=1x the codes adapt on every accepted sample, whatever the value of `cold_reset`.
- R9: `deadline_sel` is valid only when exactly one bit is set: bit0 selects 0.50, bit1 selects 0.75 and bit2 selects 1.00 of the master period. A valid value appears unchanged on `phase_sel`.
- R10: Any other `deadline_sel` value sets `config_error`=1, drives `phase_sel`=000 and holds both codes as in fixed mode.
- R11: In closed loop with a return delay that falls as the drive gets faster, each code settles within one LSB of its switching point and keeps toggling its LSB there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, synchronous; loads the initial codes |
| mode_sel | input | 2 | 00 fixed, 01 adapt during cold reset only, 1x always adapt |
| init_pu | input | 4 | Initial pull-up code |
| init_pd | input | 4 | Initial pull-down code |
| deadline_sel | input | 3 | One-hot deadline choice (bit0 0.50, bit1 0.75, bit2 1.00) |
| cold_reset | input | 1 | Cold reset phase indication |
| probe_out | output | 1 | Test drive on the reference output |
| sample_valid | input | 1 | Return sample is offered |
| sample_ready | output | 1 | Block awaits a sample for the current probe edge |
| sample_in | input | 1 | Return level seen at the deadline |
| pu_code | output | 4 | Pull-up strength code (15 fastest) |
| pd_code | output | 4 | Pull-down strength code (0 fastest) |
| phase_sel | output | 3 | Deadline selection for the sample-phase logic |
| config_error | output | 1 | Reserved deadline value in use |

## Verification
On every cycle, the assertions check the following. The codes hold when no sample is accepted, when the mode is fixed, when the configuration is in error, and after cold reset ends in mode 01. A rising measurement never moves `pd_code`, and a falling one never moves `pu_code`. Neither code wraps between 0 and 15. `sample_ready` drops after each handshake, and each new wait begins with an inverted probe level. Only the bench scenarios can show that the step direction is right for each sample value, that the loop settles and dithers around a modelled return delay, and that the codes freeze at the right values when cold reset ends.

// File: rtl/slew_pkg.sv
package slew_pkg;
  localparam int CODE_W = 4;
  localparam int SEL_W  = 3;
  localparam int MODE_W = 2;

  typedef enum logic {
    ST_LAUNCH = 1'b0,
    ST_AWAIT  = 1'b1
  } probe_st_t;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_t;

  function automatic logic sel_is_onehot(input logic [SEL_W-1:0] sel);
    return ($countones(sel) == 1);
  endfunction

  function automatic logic mode_allows(input logic [MODE_W-1:0] mode,
                                       input logic cold);
    return mode[1] | (mode[0] & cold);
  endfunction
endpackage

// File: rtl/slew_cfg_decode.sv
module slew_cfg_decode
  import slew_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int MW = MODE_W
) (
  input  logic [MW-1:0] mode_sel,
  input  logic [SW-1:0] deadline_sel,
  input  logic          cold_reset,
  output logic [SW-1:0] phase_sel,
  output logic          config_error,
  output logic          adapt_en
);
  logic sel_ok;

  always_comb begin
    sel_ok       = sel_is_onehot(deadline_sel);
    config_error = !sel_ok;
    phase_sel    = sel_ok ? deadline_sel : '0;
    adapt_en     = sel_ok && mode_allows(mode_sel, cold_reset);
  end
endmodule

// File: rtl/slew_probe_seq.sv
module slew_probe_seq
  import slew_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample_valid,
  output logic  probe_out,
  output logic  sample_ready,
  output logic  meas_fire,
  output edge_t meas_edge
);
  probe_st_t state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_LAUNCH;
      probe_out <= 1'b0;
    end else begin
      case (state_q)
        ST_LAUNCH: begin
          probe_out <= ~probe_out;
          state_q   <= ST_AWAIT;
        end
        default: begin
          if (sample_valid) state_q <= ST_LAUNCH;
        end
      endcase
    end
  end

  always_comb begin
    sample_ready = (state_q == ST_AWAIT);
    meas_fire    = sample_ready && sample_valid;
    meas_edge    = probe_out ? EDGE_RISE : EDGE_FALL;
  end
endmodule

// File: rtl/slew_code_track.sv
module slew_code_track #(
  parameter int CW        = 4,
  parameter bit FAST_HIGH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] init_code,
  input  logic          step_en,
  input  logic          early,
  output logic [CW-1:0] code
);
  localparam logic [CW-1:0] CODE_TOP = '1;
  localparam logic [CW-1:0] CODE_BOT = '0;

  logic go_up;

  generate
    if (FAST_HIGH) begin : g_fast_high
      assign go_up = !early;
    end else begin : g_fast_low
      assign go_up = early;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= init_code;
    end else if (step_en) begin
      if (go_up && code != CODE_TOP)       code <= code + 1'b1;
      else if (!go_up && code != CODE_BOT) code <= code - 1'b1;
    end
  end
endmodule

// File: rtl/slew_ctrl.sv
module slew_ctrl
  import slew_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int SW = SEL_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_sel,
  input  logic [CW-1:0] init_pu,
  input  logic [CW-1:0] init_pd,
  input  logic [SW-1:0] deadline_sel,
  input  logic          cold_reset,
  output logic          probe_out,
  input  logic          sample_valid,
  output logic          sample_ready,
  input  logic          sample_in,
  output logic [CW-1:0] pu_code,
  output logic [CW-1:0] pd_code,
  output logic [SW-1:0] phase_sel,
  output logic          config_error
);
  logic  adapt_en;
  logic  meas_fire;
  edge_t meas_edge;
  logic  edge_early;
  logic  pu_step;
  logic  pd_step;

  slew_cfg_decode #(.SW(SW), .MW(MW)) u_cfg (
    .mode_sel     (mode_sel),
    .deadline_sel (deadline_sel),
    .cold_reset   (cold_reset),
    .phase_sel    (phase_sel),
    .config_error (config_error),
    .adapt_en     (adapt_en)
  );

  slew_probe_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .probe_out    (probe_out),
    .sample_ready (sample_ready),
    .meas_fire    (meas_fire),
    .meas_edge    (meas_edge)
  );

  always_comb begin
    edge_early = (meas_edge == EDGE_RISE) ? sample_in : !sample_in;
    pu_step    = meas_fire && adapt_en && (meas_edge == EDGE_RISE);
    pd_step    = meas_fire && adapt_en && (meas_edge == EDGE_FALL);
  end

  slew_code_track #(.CW(CW), .FAST_HIGH(1'b1)) u_pu (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_code (init_pu),
    .step_en   (pu_step),
    .early     (edge_early),
    .code      (pu_code)
  );

  slew_code_track #(.CW(CW), .FAST_HIGH(1'b0)) u_pd (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_code (init_pd),
    .step_en   (pd_step),
    .early     (edge_early),
    .code      (pd_code)
  );
endmodule

// File: rtl/slew_ctrl_chk.sv
module slew_ctrl_chk #(
  parameter int CW = 4,
  parameter int SW = 3,
  parameter int MW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [MW-1:0] mode_sel,
  input logic [CW-1:0] init_pu,
  input logic [CW-1:0] init_pd,
  input logic [SW-1:0] deadline_sel,
  input logic          cold_reset,
  input logic          probe_out,
  input logic          sample_valid,
  input logic          sample_ready,
  input logic          sample_in,
  input logic [CW-1:0] pu_code,
  input logic [CW-1:0] pd_code,
  input logic [SW-1:0] phase_sel,
  input logic          config_error
);
  logic hs;
  assign hs = sample_valid && sample_ready;

  // R2: no accepted sample, no code movement
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> ($stable(pu_code) && $stable(pd_code)));

  // R2: ready drops after a handshake
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> !sample_ready);

  // R2: each wait starts on a new probe level
  p_probe_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_ready) |-> (probe_out != $past(probe_out)));

  // R3: rising measurement leaves the pull-down code alone
  p_rise_pd_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && probe_out) |=> $stable(pd_code));

  // R4: falling measurement leaves the pull-up code alone
  p_fall_pu_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !probe_out) |=> $stable(pu_code));

  // R5: no wrap at either end
  p_pu_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_code == '1) |=> (pu_code != '0));
  p_pd_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_code == '0) |=> (pd_code != '1));

  // R6: fixed mode holds
  p_fixed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> ($stable(pu_code) && $stable(pd_code)));

  // R7: boot-only mode freezes outside cold reset
  p_boot_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && !cold_reset) |=> ($stable(pu_code) && $stable(pd_code)));

  // R10: reserved deadline holds codes and blanks phase
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> ($stable(pu_code) && $stable(pd_code)));
  p_cfg_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> (phase_sel == '0));
endmodule

bind slew_ctrl slew_ctrl_chk #(.CW(CW), .SW(SW), .MW(MW)) u_chk (.*);

// File: tb/slew_ctrl_tb.sv
`timescale 1ns/1ps
module slew_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [3:0] init_pu = 4'd0;
  logic [3:0] init_pd = 4'd0;
  logic [2:0] deadline_sel = 3'b001;
  logic       cold_reset = 1'b0;
  logic       probe_out;
  logic       sample_valid = 1'b0;
  logic       sample_ready;
  logic       sample_in = 1'b0;
  logic [3:0] pu_code;
  logic [3:0] pd_code;
  logic [2:0] phase_sel;
  logic       config_error;

  int errors = 0;
  int checks = 0;
  int thr = 12;
  logic [3:0] exp_pu, exp_pd;
  logic       last_edge;
  logic [7:0] exp_q[$];
  bit         done = 0;

  always #2.5 clk = ~clk;

  slew_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] pu, input logic [3:0] pd,
                          input logic [1:0] md, input logic [2:0] dl, input logic cold);
    @(negedge clk);
    rst_n = 1'b0; sample_valid = 1'b0;
    init_pu = pu; init_pd = pd; mode_sel = md; deadline_sel = dl; cold_reset = cold;
    repeat (3) @(negedge clk);
    chk(pu_code == pu, "R1 pu init", pu_code, pu);
    chk(pd_code == pd, "R1 pd init", pd_code, pd);
    chk(probe_out == 1'b0 && sample_ready == 1'b0, "R1 probe/ready idle",
        {probe_out, sample_ready}, 0);
    rst_n = 1'b1;
    exp_pu = pu; exp_pd = pd; last_edge = 1'b0;
  endtask

  // Driver: offers one sample per launch, predicts the resulting codes
  task automatic measure();
    logic e, early, adapt;
    @(negedge clk);
    while (!sample_ready) @(negedge clk);
    e = probe_out;
    chk(e != last_edge, "R2 probe alternates", e, !last_edge);
    last_edge = e;
    if (e) early = (20 - int'(exp_pu)) <= thr;
    else   early = (5 + int'(exp_pd)) <= thr;
    sample_in = e ? early : !early;
    sample_valid = 1'b1;
    adapt = ($countones(deadline_sel) == 1) &&
            (mode_sel[1] || (mode_sel == 2'b01 && cold_reset));
    if (adapt) begin
      if (e) begin
        if (early && exp_pu != 0) exp_pu--;
        else if (!early && exp_pu != 15) exp_pu++;
      end else begin
        if (early && exp_pd != 15) exp_pd++;
        else if (!early && exp_pd != 0) exp_pd--;
      end
    end
    @(negedge clk);
    sample_valid = 1'b0;
    exp_q.push_back({exp_pu, exp_pd});
  endtask

  // Monitor: compares codes after each accepted sample
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] ex;
      ex = exp_q.pop_front();
      chk(pu_code == ex[7:4], "R3/R8 pu step", pu_code, ex[7:4]);
      chk(pd_code == ex[3:0], "R4/R8 pd step", pd_code, ex[3:0]);
      chk(!sample_ready, "R2 ready low after accept", sample_ready, 0);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev_pu;
    int pu_moves;

    // R11 / R8: continuous adaptation converges and dithers
    do_reset(4'd2, 4'd14, 2'b10, 3'b010, 1'b0);
    thr = 12;
    chk(phase_sel == 3'b010 && !config_error, "R9 phase 0.75", phase_sel, 3'b010);
    for (int i = 0; i < 40; i++) measure();
    chk(pu_code inside {4'd7, 4'd8}, "R11 pu settled", pu_code, 8);
    chk(pd_code inside {4'd7, 4'd8}, "R11 pd settled", pd_code, 7);
    pu_moves = 0;
    for (int i = 0; i < 8; i++) begin
      prev_pu = pu_code;
      measure();
      #2;
      if (pu_code != prev_pu) pu_moves++;
    end
    chk(pu_moves >= 2, "R11 LSB dither", pu_moves, 2);

    // R5: saturation at the slow end
    do_reset(4'd1, 4'd14, 2'b11, 3'b001, 1'b0);
    thr = 100;
    chk(phase_sel == 3'b001, "R9 phase 0.50", phase_sel, 3'b001);
    for (int i = 0; i < 8; i++) measure();
    chk(pu_code == 4'd0, "R5 pu floor", pu_code, 0);
    chk(pd_code == 4'd15, "R5 pd ceiling", pd_code, 15);

    // R5: saturation at the fast end
    do_reset(4'd14, 4'd1, 2'b10, 3'b100, 1'b1);
    thr = -100;
    chk(phase_sel == 3'b100, "R9 phase 1.00", phase_sel, 3'b100);
    for (int i = 0; i < 8; i++) measure();
    chk(pu_code == 4'd15, "R5 pu ceiling", pu_code, 15);
    chk(pd_code == 4'd0, "R5 pd floor", pd_code, 0);

    // R7: boot-only adaptation then freeze
    do_reset(4'd2, 4'd14, 2'b01, 3'b010, 1'b1);
    thr = 12;
    for (int i = 0; i < 6; i++) measure();
    chk(pu_code == 4'd5, "R7 pu after cold reset", pu_code, 5);
    chk(pd_code == 4'd11, "R7 pd after cold reset", pd_code, 11);
    @(negedge clk); cold_reset = 1'b0;
    for (int i = 0; i < 6; i++) measure();
    chk(pu_code == 4'd5, "R7 pu frozen", pu_code, 5);
    chk(pd_code == 4'd11, "R7 pd frozen", pd_code, 11);

    // R6: fixed mode
    do_reset(4'd3, 4'd9, 2'b00, 3'b001, 1'b1);
    for (int i = 0; i < 8; i++) measure();
    chk(pu_code == 4'd3, "R6 pu fixed", pu_code, 3);
    chk(pd_code == 4'd9, "R6 pd fixed", pd_code, 9);

    // R10: reserved deadline
    do_reset(4'd4, 4'd10, 2'b11, 3'b011, 1'b1);
    chk(config_error == 1'b1, "R10 error flag", config_error, 1);
    chk(phase_sel == 3'b000, "R10 phase blank", phase_sel, 0);
    for (int i = 0; i < 6; i++) measure();
    chk(pu_code == 4'd4, "R10 pu held", pu_code, 4);
    chk(pd_code == 4'd10, "R10 pd held", pd_code, 10);
    @(negedge clk); deadline_sel = 3'b000;
    #1;
    chk(config_error == 1'b1, "R10 zero deadline", config_error, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule